// File: doc/BRIEF.md
# Dual-Clock Dual-Port Synchronous RAM

This block is a true dual-port word memory shared by two agents that each run on their own clock. The two clocks need not be related in frequency or phase. Each side, called port A and port B, can read or write any word on any cycle. Words are 18 bits wide and split into two 9-bit lanes. Each lane has its own active-low enable, so a port can write or read a single lane without touching the other.

A port performs an access only when both of its chip selects are asserted: the low-true select must be low and the high-true select must be high. Address, selects, the read/write line and the lane enables are all sampled on the rising edge of that port's clock.

Read latency is chosen per port by a static strap, giving either one-register (flow-through) or two-register (pipelined) timing. Tying the strap high selects the pipelined timing, which is the usual setting. An output enable masks the read bus combinationally.

Each port also has a collision flag. The flag warns that the other port touched the same word during an overlapping cycle, so software can treat that read value as unreliable. The word count is a parameter, 256 by default.

Top module: `dpr_dualclk`

## Requirements
- R1: A selected access with the read/write line low stores the enabled lanes of the write data at the sampled address. The stored word is then readable from either port.
- R2: A port is selected only when its low-true select is 0 and its high-true select is 1. Any other combination performs no access, leaves memory unchanged and produces a zero read bus.
- R3: Lane enables are active low. Enable bit 0 controls bits 8:0 and enable bit 1 controls bits 17:9. On a write, a lane whose enable is high keeps its previous contents.
- R4: On a read, a lane whose enable is high returns zero on the read bus.
- R5: With the latency strap low (flow-through), read data appears after the first rising edge that samples the read and holds for one cycle.
- R6: With the latency strap high (pipelined), read data appears after the second rising edge. After the first edge the bus still reads zero.
- R7: While the output enable is high, the read bus is zero, with no clock needed. The bus is also zero when the output stage holds no read, for example after a write.
- R8: When both ports are selected on the same address in overlapping cycles, the port A flag rises within 3 port A clocks and the port B flag rises within 4 port B clocks.
- R9: No collision flag rises when the two ports use different addresses or when one port is unselected.
- R10: After reset, both read buses and both collision flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| pa_sel_n | input | 1 | Port A low-true select |
| pa_sel | input | 1 | Port A high-true select |
| pa_rnw | input | 1 | Port A read (1) / write (0) |
| pa_lane_n | input | 2 | Port A lane enables, active low |
| pa_addr | input | AW | Port A word address |
| pa_wdata | input | 18 | Port A write data |
| pa_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| pa_pipe | input | 1 | Port A latency strap: 1 pipelined, 0 flow-through |
| pa_rdata | output | 18 | Port A read data |
| pa_coll | output | 1 | Port A collision flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| pb_sel_n | input | 1 | Port B low-true select |
| pb_sel | input | 1 | Port B high-true select |
| pb_rnw | input | 1 | Port B read (1) / write (0) |
| pb_lane_n | input | 2 | Port B lane enables, active low |
| pb_addr | input | AW | Port B word address |
| pb_wdata | input | 18 | Port B write data |
| pb_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| pb_pipe | input | 1 | Port B latency strap: 1 pipelined, 0 flow-through |
| pb_rdata | output | 18 | Port B read data |
| pb_coll | output | 1 | Port B collision flag |

## Verification
The bench writes a word through one port and reads it back through the other, at both the lowest and the highest address. A design that stored data only in its own port's bank, or mishandled the end addresses, would return stale or wrong words.

It samples the pipelined bus one cycle early to confirm it is still zero. A design with a swapped or missing latency stage would show data a cycle early or a cycle late.

Lane-masked writes over a known word, and lane-masked reads, expose a design that writes whole words or leaks disabled lanes. The half-select combinations would corrupt memory or drive the bus in a design that decodes only one of the two selects. The output enable is toggled mid-cycle to catch a design that registers it.

Same-address overlap between the two clocks must raise both flags, and disjoint addresses must leave them low. A missing clock-crossing path or an over-eager comparator fails one of these two checks.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 9;
  localparam int NLANES = 2;
  localparam int WORD_W = LANE_W * NLANES;
  typedef logic [NLANES-1:0] lane_mask_t;
endpackage

// File: rtl/dpr_lane_bank.sv
// One lane of storage built as two single-writer banks. Each bank is written
// only from its own port's clock. A stored word is the XOR of the two banks.
module dpr_lane_bank #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int LW    = 9
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          we_a,
  input  logic          re_a,
  input  logic [AW-1:0] addr_a,
  input  logic [LW-1:0] wd_a,
  output logic [LW-1:0] rd_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          we_b,
  input  logic          re_b,
  input  logic [AW-1:0] addr_b,
  input  logic [LW-1:0] wd_b,
  output logic [LW-1:0] rd_b
);
  logic [LW-1:0] bank_a [DEPTH] = '{default: '0};
  logic [LW-1:0] bank_b [DEPTH] = '{default: '0};

  always_ff @(posedge clk_a) begin
    if (we_a) bank_a[addr_a] <= wd_a ^ bank_b[addr_a];
    if (rst_a)     rd_a <= '0;
    else if (re_a) rd_a <= bank_a[addr_a] ^ bank_b[addr_a];
    else           rd_a <= '0;
  end

  always_ff @(posedge clk_b) begin
    if (we_b) bank_b[addr_b] <= wd_b ^ bank_a[addr_b];
    if (rst_b)     rd_b <= '0;
    else if (re_b) rd_b <= bank_a[addr_b] ^ bank_b[addr_b];
    else           rd_b <= '0;
  end
endmodule

// File: rtl/dpr_port.sv
// Per-port control: select decode, lane strobes, the latency stages and the
// output enable gate.
module dpr_port
  import dpr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              rnw,
  input  lane_mask_t        lane_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [WORD_W-1:0] rd1,
  output logic              acc,
  output lane_mask_t        we_l,
  output lane_mask_t        re_l,
  output logic [WORD_W-1:0] rdata
);
  logic              v1, v2;
  logic [WORD_W-1:0] d2;
  logic              out_v;
  logic [WORD_W-1:0] out_d;
  logic [WORD_W-1:0] ft_view;

  assign acc  = !sel_n && sel;
  assign we_l = (acc && !rnw) ? ~lane_n : '0;
  assign re_l = (acc &&  rnw) ? ~lane_n : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      d2 <= '0;
    end else begin
      v1 <= acc && rnw;
      v2 <= v1;
      d2 <= rd1;
    end
  end

  assign out_v   = pipe ? v2 : v1;
  assign out_d   = pipe ? d2 : rd1;
  assign rdata   = (!oe_n && out_v) ? out_d : '0;
  assign ft_view = v1 ? rd1 : '0;

  // R7
  oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (rdata == '0));
  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe && acc && !rnw) |=> (rdata == '0));
  // R6
  pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe && $past(pipe) && !oe_n && $past(!oe_n)) |-> (rdata == $past(ft_view)));
  // R4
  lane_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe && acc && rnw && lane_n[0]) |=> (rdata[LANE_W-1:0] == '0));
endmodule

// File: rtl/dpr_collide.sv
// Same-address detector. Port A's clock is the reference: each A edge compares
// A's sampled access with B's last registered access. The A-side result is
// carried into the B domain through two flops.
module dpr_collide #(
  parameter int AW = 8
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          acc_a,
  input  logic [AW-1:0] addr_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          acc_b,
  input  logic [AW-1:0] addr_b,
  output logic          coll_a,
  output logic          coll_b
);
  logic          b_vld_q;
  logic [AW-1:0] b_addr_q;
  logic          hit;
  logic          sync1, sync2;

  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      b_vld_q  <= 1'b0;
      b_addr_q <= '0;
      sync1    <= 1'b0;
      sync2    <= 1'b0;
    end else begin
      b_vld_q  <= acc_b;
      b_addr_q <= addr_b;
      sync1    <= coll_a;
      sync2    <= sync1;
    end
  end

  assign hit = acc_a && b_vld_q && (addr_a == b_addr_q);

  always_ff @(posedge clk_a) begin
    if (rst_a) coll_a <= 1'b0;
    else       coll_a <= hit;
  end

  assign coll_b = sync2;

  // R9
  idle_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    !acc_a |=> !coll_a);
endmodule

// File: rtl/dpr_dualclk.sv
module dpr_dualclk
  import dpr_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              pa_sel_n,
  input  logic              pa_sel,
  input  logic              pa_rnw,
  input  logic [NLANES-1:0] pa_lane_n,
  input  logic [AW-1:0]     pa_addr,
  input  logic [WORD_W-1:0] pa_wdata,
  input  logic              pa_oe_n,
  input  logic              pa_pipe,
  output logic [WORD_W-1:0] pa_rdata,
  output logic              pa_coll,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              pb_sel_n,
  input  logic              pb_sel,
  input  logic              pb_rnw,
  input  logic [NLANES-1:0] pb_lane_n,
  input  logic [AW-1:0]     pb_addr,
  input  logic [WORD_W-1:0] pb_wdata,
  input  logic              pb_oe_n,
  input  logic              pb_pipe,
  output logic [WORD_W-1:0] pb_rdata,
  output logic              pb_coll
);
  logic              acc_a, acc_b;
  lane_mask_t        we_a, re_a, we_b, re_b;
  logic [WORD_W-1:0] rd1_a, rd1_b;

  dpr_port #(.AW(AW)) port_a_i (
    .clk(clk_a), .rst(rst_a), .sel_n(pa_sel_n), .sel(pa_sel), .rnw(pa_rnw),
    .lane_n(pa_lane_n), .oe_n(pa_oe_n), .pipe(pa_pipe), .rd1(rd1_a),
    .acc(acc_a), .we_l(we_a), .re_l(re_a), .rdata(pa_rdata)
  );

  dpr_port #(.AW(AW)) port_b_i (
    .clk(clk_b), .rst(rst_b), .sel_n(pb_sel_n), .sel(pb_sel), .rnw(pb_rnw),
    .lane_n(pb_lane_n), .oe_n(pb_oe_n), .pipe(pb_pipe), .rd1(rd1_b),
    .acc(acc_b), .we_l(we_b), .re_l(re_b), .rdata(pb_rdata)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    dpr_lane_bank #(.DEPTH(DEPTH), .AW(AW), .LW(LANE_W)) bank_i (
      .clk_a(clk_a), .rst_a(rst_a), .we_a(we_a[g]), .re_a(re_a[g]),
      .addr_a(pa_addr), .wd_a(pa_wdata[g*LANE_W +: LANE_W]),
      .rd_a(rd1_a[g*LANE_W +: LANE_W]),
      .clk_b(clk_b), .rst_b(rst_b), .we_b(we_b[g]), .re_b(re_b[g]),
      .addr_b(pb_addr), .wd_b(pb_wdata[g*LANE_W +: LANE_W]),
      .rd_b(rd1_b[g*LANE_W +: LANE_W])
    );
  end

  dpr_collide #(.AW(AW)) coll_i (
    .clk_a(clk_a), .rst_a(rst_a), .acc_a(acc_a), .addr_a(pa_addr),
    .clk_b(clk_b), .rst_b(rst_b), .acc_b(acc_b), .addr_b(pb_addr),
    .coll_a(pa_coll), .coll_b(pb_coll)
  );
endmodule

// File: tb/dpr_dualclk_tb.sv
module dpr_dualclk_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int W     = 18;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic pa_sel_n = 1, pa_sel = 0, pa_rnw = 1, pa_oe_n = 0, pa_pipe = 0;
  logic pb_sel_n = 1, pb_sel = 0, pb_rnw = 1, pb_oe_n = 0, pb_pipe = 1;
  logic [1:0] pa_lane_n = 2'b11, pb_lane_n = 2'b11;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  logic [W-1:0] pa_wdata = '0, pb_wdata = '0, pa_rdata, pb_rdata;
  logic pa_coll, pb_coll;

  int checks = 0, fails = 0;
  logic [W-1:0] ref_mem [DEPTH];
  bit mon_en = 0, seen_a = 0, seen_b = 0;

  always #4 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  dpr_dualclk #(.DEPTH(DEPTH)) dut_i (.*);

  always @(negedge clk_a) if (mon_en && pa_coll) seen_a = 1;
  always @(negedge clk_b) if (mon_en && pb_coll) seen_b = 1;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(bit p);
    if (!p) begin @(posedge clk_a); @(negedge clk_a); end
    else    begin @(posedge clk_b); @(negedge clk_b); end
  endtask

  task automatic drive(bit p, logic sn, logic s, logic rnw, logic [1:0] ln,
                       logic [AW-1:0] ad, logic [W-1:0] wd);
    if (!p) begin
      pa_sel_n = sn; pa_sel = s; pa_rnw = rnw; pa_lane_n = ln; pa_addr = ad; pa_wdata = wd;
    end else begin
      pb_sel_n = sn; pb_sel = s; pb_rnw = rnw; pb_lane_n = ln; pb_addr = ad; pb_wdata = wd;
    end
  endtask

  task automatic idle(bit p);
    drive(p, 1'b1, 1'b0, 1'b1, 2'b11, '0, '0);
  endtask

  function automatic logic [W-1:0] rd(bit p);
    return p ? pb_rdata : pa_rdata;
  endfunction

  function automatic logic [W-1:0] lmask(logic [1:0] ln);
    return {{9{~ln[1]}}, {9{~ln[0]}}};
  endfunction

  task automatic align(bit p);
    if (!p) @(negedge clk_a); else @(negedge clk_b);
  endtask

  task automatic do_write(bit p, logic [AW-1:0] ad, logic [W-1:0] d, logic [1:0] ln);
    align(p);
    drive(p, 1'b0, 1'b1, 1'b0, ln, ad, d);
    tick(p);
    idle(p);
    ref_mem[ad] = (ref_mem[ad] & ~lmask(ln)) | (d & lmask(ln));
  endtask

  task automatic do_read(bit p, logic [AW-1:0] ad, logic [1:0] ln, string req);
    logic [W-1:0] exp;
    logic pipe;
    exp = ref_mem[ad] & lmask(ln);
    pipe = p ? pb_pipe : pa_pipe;
    align(p);
    drive(p, 1'b0, 1'b1, 1'b1, ln, ad, '0);
    tick(p);
    if (pipe) begin
      chk({req, " R6 early"}, rd(p), '0);
      idle(p);
      tick(p);
      chk({req, " R6"}, rd(p), exp);
    end else begin
      chk({req, " R5"}, rd(p), exp);
      idle(p);
    end
  endtask

  // R1 R5 R6: cross-port and own-port traffic in both latency modes
  task automatic t_basic();
    pa_pipe = 0; pb_pipe = 1;
    do_write(0, 8'h10, 18'h2A5C3, 2'b00);
    do_read(0, 8'h10, 2'b00, "R1 own");
    do_read(1, 8'h10, 2'b00, "R1 cross");
    do_write(1, 8'hFF, 18'h1F00E, 2'b00);
    do_write(1, 8'h00, 18'h3C0F1, 2'b00);
    do_read(0, 8'hFF, 2'b00, "R1 top addr");
    do_read(0, 8'h00, 2'b00, "R1 low addr");
    pa_pipe = 1; pb_pipe = 0;
    do_read(0, 8'h10, 2'b00, "R1 A pipelined");
    do_read(1, 8'hFF, 2'b00, "R1 B flow");
    pa_pipe = 0; pb_pipe = 1;
  endtask

  // R3: masked writes keep the disabled lane
  task automatic t_lane_write();
    do_write(0, 8'h20, 18'h3FFFF, 2'b00);
    do_write(1, 8'h20, 18'h00000, 2'b10);
    do_read(0, 8'h20, 2'b00, "R3 low lane only");
    do_write(0, 8'h20, 18'h15555, 2'b01);
    do_read(1, 8'h20, 2'b00, "R3 high lane only");
  endtask

  // R4: masked reads return zero in the disabled lane
  task automatic t_lane_read();
    do_read(0, 8'h10, 2'b01, "R4 lane0 off");
    do_read(1, 8'h10, 2'b10, "R4 lane1 off");
  endtask

  // R2: half-selected ports neither store nor drive
  task automatic t_select();
    logic [W-1:0] keep;
    keep = ref_mem[8'h10];
    align(0);
    drive(0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h10, 18'h00BAD);
    tick(0);
    drive(0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h10, 18'h00BAD);
    tick(0);
    drive(0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h10, '0);
    tick(0);
    chk("R2 no read when unselected", pa_rdata, '0);
    idle(0);
    do_read(0, 8'h10, 2'b00, "R2 memory kept");
    chk("R2 model unchanged", ref_mem[8'h10], keep);
  endtask

  // R7: output enable masks without a clock
  task automatic t_oe();
    align(0);
    drive(0, 1'b0, 1'b1, 1'b1, 2'b00, 8'h00, '0);
    tick(0);
    pa_oe_n = 1; #1;
    chk("R7 oe high", pa_rdata, '0);
    pa_oe_n = 0; #1;
    chk("R7 oe low again", pa_rdata, ref_mem[8'h00]);
    idle(0);
    do_write(0, 8'h30, 18'h12345, 2'b00);
    chk("R7 after write", pa_rdata, '0);
  endtask

  task automatic hold(bit p, logic [AW-1:0] ad, int n);
    align(p);
    drive(p, 1'b0, 1'b1, 1'b1, 2'b00, ad, '0);
    repeat (n) tick(p);
    idle(p);
  endtask

  // R8 R9: collision flags across the clock domains
  task automatic t_collide();
    seen_a = 0; seen_b = 0; mon_en = 1;
    fork
      hold(0, 8'h44, 8);
      hold(1, 8'h44, 6);
    join
    repeat (6) tick(1);
    mon_en = 0;
    chk("R8 flag A", {17'd0, seen_a}, 18'd1);
    chk("R8 flag B", {17'd0, seen_b}, 18'd1);
    seen_a = 0; seen_b = 0; mon_en = 1;
    fork
      hold(0, 8'h44, 8);
      hold(1, 8'h45, 6);
    join
    repeat (6) tick(1);
    hold(0, 8'h44, 6);
    repeat (6) tick(1);
    mon_en = 0;
    chk("R9 flag A quiet", {17'd0, seen_a}, 18'd0);
    chk("R9 flag B quiet", {17'd0, seen_b}, 18'd0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk_b);
    @(negedge clk_a); rst_a = 0;
    @(negedge clk_b); rst_b = 0;
    #1;
    chk("R10 rdata A", pa_rdata, '0);
    chk("R10 rdata B", pb_rdata, '0);
    chk("R10 flags", {16'd0, pa_coll, pb_coll}, '0);
    t_basic();
    t_lane_write();
    t_lane_read();
    t_select();
    t_oe();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule